// File: doc/BRIEF.md
# Valley Pulse Qualifier

This block sits between the demagnetization comparator of a boost power stage and the cycle scheduler. The comparator reports, as a single digital level, whether the scaled auxiliary-winding voltage is above a small positive threshold near 50 mV. When the inductor has released its energy, the drain node rings. Each falling edge of the comparator level comes just before a local minimum of the switch drain voltage. The block turns those falling edges into clean one-clock valley pulses, so the scheduler can start the next switching cycle on a valley of its choice.

A falling edge counts only if the synchronized level was high without a break for a minimum qualification time. The default is 200 ns, which is 10 clocks at 50 MHz. Shorter high intervals are treated as glitches and produce nothing. The qualification logic is held cleared while the gate drive is on and for a blanking window after it turns off. A pulse is emitted only while the scheduler signals that it is ready. Every qualifying valley in a ringing train produces its own pulse, because switching may start on a later valley than the first. The block also reports, as a status level, whether a qualified high interval is currently in progress.

Top module: `valley_pulse_gen`

## Requirements
- R1: While reset is asserted, and in the first cycles after it, valley_o and qual_o are 0.
- R2: A valley pulse follows a high-to-low change of the comparator level. The comparator passes through a 2-flop synchronizer. valley_o is high in the clock cycle that follows the third rising clock edge after cmp_raw_i falls.
- R3: A falling edge produces a pulse only if the synchronized level was sampled high on at least QUAL_CYC consecutive clock edges. QUAL_CYC is 10 for the defaults of 50 MHz and 200 ns. A high run of QUAL_CYC-1 samples produces no pulse.
- R4: Any low sample clears the high-time count. Two high runs of QUAL_CYC-1 samples, separated by a single low sample, produce no pulse.
- R5: valley_o is exactly one clock wide. A level that stays low after a pulse produces no further pulse.
- R6: While gate_on_i is 1, the qualification is held cleared, no pulse is emitted and qual_o is 0.
- R7: After gate_on_i falls, qualification stays held for BLANK_CYC clock edges. BLANK_CYC is 20 for the defaults of 50 MHz and 400 ns. A level that is high through the gate pulse and falls within this window plus the qualification time produces no pulse. A later fall produces one pulse.
- R8: A qualified falling edge seen while sched_ready_i is 0 produces no pulse.
- R9: Every qualifying valley in a train of ringing cycles produces its own pulse.
- R10: qual_o is 1 while the high-time count has reached QUAL_CYC and the block is not held. It returns to 0 once a low sample has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cmp_raw_i | input | 1 | Unsynchronized demagnetization comparator level |
| gate_on_i | input | 1 | Gate drive currently on |
| sched_ready_i | input | 1 | Cycle scheduler accepts valley pulses |
| valley_o | output | 1 | One-clock valley pulse |
| qual_o | output | 1 | Qualified high interval in progress |

## Verification
A falling comparator input reaches the pulse register on the third rising edge after the change: two synchronizer flops, then the pulse flop. The bench drives inputs on falling clock edges. It then samples valley_o on each of the next six falling edges, and expects the pulse at exactly the third sample and on no other. For the gate hold and the blanking window, the bench counts the edges from the fall of gate_on_i: 20 edges of blanking followed by 10 qualifying samples. It places the comparator fall clearly inside that span or clearly after it. The status output is read one edge after the counter has cleared or saturated.

// File: rtl/vpg_pkg.sv
package vpg_pkg;

  // Cycles needed to cover a duration in ns at a clock in Hz, rounded up.
  function automatic int ns_to_cyc(input longint unsigned clk_hz,
                                   input longint unsigned dur_ns);
    longint unsigned prod;
    prod = clk_hz * dur_ns;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  function automatic int at_least_one(input int val);
    return (val < 1) ? 1 : val;
  endfunction

endpackage

// File: rtl/vpg_sync.sv
module vpg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d = d_i;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/vpg_blank.sv
module vpg_blank #(
  parameter int BLANK_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_on_i,
  output logic busy_o
);

  localparam int CNT_W = $clog2(BLANK_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BLANK_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Reload while the gate is on, count down afterwards.
  always_comb begin
    cnt_en = gate_on_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (gate_on_i)         cnt_d = CNT_LOAD;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  // R7: blanking is active on the first edge after the gate turns off
  a_r7_blank_after_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_on_i) |-> busy_o);

  a_r7_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LOAD);

endmodule

// File: rtl/vpg_qual.sv
module vpg_qual #(
  parameter int QUAL_CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic hold_i,
  input  logic ready_i,
  output logic pulse_o,
  output logic qual_o
);

  localparam int CNT_W = $clog2(QUAL_CYC + 1);
  localparam logic [CNT_W-1:0] QUAL_MAX = CNT_W'(QUAL_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             armed;

  assign armed = (cnt_q == QUAL_MAX);

  // High-time counter: saturates at the qualification count and is cleared
  // by any low sample or by a hold.
  always_comb begin
    cnt_d = cnt_q;
    if (hold_i || !lvl_i) cnt_d = '0;
    else if (!armed)      cnt_d = cnt_q + 1'b1;
  end

  // A low sample while armed is a qualified falling edge.
  always_comb begin
    pulse_d = !hold_i && !lvl_i && armed && ready_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;
  assign qual_o  = armed && !hold_i;

  // R2: a pulse follows a low sample of the level
  a_r2_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> !$past(lvl_i));

  // R3: a pulse needs a qualified interval before it
  a_r3_needs_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> $past(qual_o));

  // R5: one clock wide
  a_r5_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);

  // R8: scheduler must have been ready
  a_r8_ready_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> $past(ready_i));

  // R10: the count never passes its saturation value
  a_r10_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= QUAL_MAX);

endmodule

// File: rtl/valley_pulse_gen.sv
module valley_pulse_gen #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int QUAL_NS     = 200,
  parameter int BLANK_NS    = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_raw_i,
  input  logic gate_on_i,
  input  logic sched_ready_i,
  output logic valley_o,
  output logic qual_o
);

  import vpg_pkg::*;

  localparam int QUAL_CYC  = at_least_one(ns_to_cyc(longint'(CLK_HZ), longint'(QUAL_NS)));
  localparam int BLANK_CYC = at_least_one(ns_to_cyc(longint'(CLK_HZ), longint'(BLANK_NS)));

  logic cmp_sync;
  logic blank_busy;
  logic hold;

  vpg_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmp_raw_i),
    .q_o    (cmp_sync)
  );

  vpg_blank #(.BLANK_CYC(BLANK_CYC)) blank_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gate_on_i (gate_on_i),
    .busy_o    (blank_busy)
  );

  assign hold = gate_on_i || blank_busy;

  vpg_qual #(.QUAL_CYC(QUAL_CYC)) qual_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (cmp_sync),
    .hold_i  (hold),
    .ready_i (sched_ready_i),
    .pulse_o (valley_o),
    .qual_o  (qual_o)
  );

  // R6: no pulse in the cycle after the gate is seen on
  a_r6_quiet_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_on_i |=> !valley_o);

  // R6: status is low while the gate is on
  a_r6_no_qual_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_on_i |-> !qual_o);

endmodule

// File: tb/valley_pulse_gen_tb.sv
module valley_pulse_gen_tb_top;

  localparam time CLK_PERIOD = 20ns;
  localparam int  QC = 10;   // qualification samples at 50 MHz / 200 ns
  localparam int  BC = 20;   // blanking edges at 50 MHz / 400 ns

  logic clk = 1'b0;
  logic rst_n;
  logic cmp, gate, rdy;
  logic valley, qual;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  valley_pulse_gen dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cmp_raw_i     (cmp),
    .gate_on_i     (gate),
    .sched_ready_i (rdy),
    .valley_o      (valley),
    .qual_o        (qual)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    cmp = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drop the level, watch six falling edges, return pulse count and position.
  task automatic watch_fall(output int cnt, output int pos);
    cnt = 0; pos = 0;
    cmp = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (valley) begin cnt++; pos = i; end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cmp = 1'b0; gate = 1'b0; rdy = 1'b1;
    repeat (3) @(negedge clk);
    check(valley == 1'b0, "R1 valley in reset", valley, 0);
    check(qual == 1'b0, "R1 qual in reset", qual, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(valley == 1'b0 && qual == 1'b0, "R1 after release", {valley, qual}, 0);
  endtask

  task automatic t_exact_qual;
    int c, p;
    idle(4);
    cmp = 1'b1;
    repeat (QC) @(negedge clk);
    watch_fall(c, p);
    check(c == 1, "R3 run of QC gives one pulse", c, 1);
    check(p == 3, "R2 pulse latency", p, 3);
  endtask

  task automatic t_short;
    int c, p;
    idle(4);
    cmp = 1'b1;
    repeat (QC-1) @(negedge clk);
    watch_fall(c, p);
    check(c == 0, "R3 run of QC-1 gives none", c, 0);
    check(qual == 1'b0, "R10 qual after short run", qual, 0);
  endtask

  task automatic t_split;
    int c, p;
    idle(4);
    cmp = 1'b1; repeat (QC-1) @(negedge clk);
    cmp = 1'b0; @(negedge clk);
    cmp = 1'b1; repeat (QC-1) @(negedge clk);
    watch_fall(c, p);
    check(c == 0, "R4 low sample clears count", c, 0);
  endtask

  task automatic t_width_and_qual;
    int c, p, extra;
    idle(4);
    cmp = 1'b1;
    repeat (QC+8) @(negedge clk);
    check(qual == 1'b1, "R10 qual after long high", qual, 1);
    watch_fall(c, p);
    check(c == 1 && p == 3, "R5 one clock wide", c, 1);
    check(qual == 1'b0, "R10 qual cleared after low", qual, 0);
    extra = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (valley) extra++;
    end
    check(extra == 0, "R5 no repeat while low", extra, 0);
  endtask

  task automatic t_gate;
    int c, p;
    idle(4);
    gate = 1'b1;
    cmp  = 1'b1;
    repeat (QC+10) @(negedge clk);
    check(qual == 1'b0, "R6 qual during gate", qual, 0);
    watch_fall(c, p);
    check(c == 0, "R6 no pulse during gate", c, 0);
    gate = 1'b0;
    idle(BC+4);
  endtask

  task automatic t_blank;
    int c, p;
    idle(4);
    cmp = 1'b1; gate = 1'b1;
    repeat (3) @(negedge clk);
    gate = 1'b0;
    repeat (BC + QC - 8) @(negedge clk);
    watch_fall(c, p);
    check(c == 0, "R7 fall inside blanking", c, 0);
    idle(4);
    cmp = 1'b1; gate = 1'b1;
    repeat (3) @(negedge clk);
    gate = 1'b0;
    repeat (BC + QC + 8) @(negedge clk);
    watch_fall(c, p);
    check(c == 1 && p == 3, "R7 fall after blanking", c, 1);
  endtask

  task automatic t_ready;
    int c, p;
    idle(4);
    rdy = 1'b0;
    cmp = 1'b1;
    repeat (QC+5) @(negedge clk);
    watch_fall(c, p);
    check(c == 0, "R8 not ready suppresses", c, 0);
    rdy = 1'b1;
  endtask

  task automatic t_ring;
    int c, p, sum;
    idle(4);
    sum = 0;
    for (int k = 0; k < 3; k++) begin
      cmp = 1'b1;
      repeat (QC+2) @(negedge clk);
      watch_fall(c, p);
      sum += c;
    end
    check(sum == 3, "R9 every valley pulses", sum, 3);
  endtask

  initial begin
    t_reset();
    t_exact_qual();
    t_short();
    t_split();
    t_width_and_qual();
    t_gate();
    t_blank();
    t_ready();
    t_ring();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule